// File: doc/BRIEF.md
# OTP User-Mode Byte Read Controller

This block sits on a 32-bit register bus and lets software fetch single bytes from a one-time-programmable array through a small user read engine. Software first switches the controller into user mode. It then loads a byte address and issues a start command. The engine holds the address, waits out a fixed access latency, places the byte in a data register and raises a completion flag. That flag drives a level interrupt. Software reads the byte, clears the flag by writing a one to it, and finally switches user mode off.

The control, address and start registers use write masks carried in the upper half of the written word. A data bit changes only when its partner mask bit, sixteen positions higher, is set in the same write. The array is byte wide and read-only. For simulation it holds a computed pattern from time zero.

Top module: `otp_user_reader`

## Requirements
- R1: After reset, every register reads back as zero and `irq` is low.
- R2: Offset 0x100 holds the user-mode bit in bit 0. A write changes it only when bit 16 of the same write is 1; otherwise the bit keeps its value.
- R3: Offset 0x104 holds a 16-bit byte address in bits 15:0. Address bit n takes the written bit n only when bit n+16 of the write is 1; the other bits keep their value. Bits 31:16 read as zero.
- R4: A write to offset 0x108 with bits 0 and 16 both set starts a read when user mode is on and no read is in progress. Status bit 2 and the data register update on the 4th rising edge after the edge that took the start. Bit 0 of offset 0x108 reads 1 while a read is in progress.
- R5: Offset 0x124 returns the fetched byte in bits 7:0, with bits 31:8 zero. The byte at address a is (13*(a mod 256) + 0x29) mod 256, because the default array has 256 entries and the address wraps modulo that depth.
- R6: A start command has no effect while user mode is off.
- R7: A start command has no effect while a read is in progress. The running read keeps the address it captured at its own start, even if the address register is rewritten meanwhile.
- R8: At offset 0x304, status bit 2 is cleared by writing 1 to bit 2. Writing 0 leaves it unchanged. If a clear and a completion land on the same edge, the bit stays set.
- R9: `irq` is high exactly when some status bit is set.
- R10: Read data appears on `bus_rdata` on the edge that samples `bus_rd`. Offsets other than the five listed above read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, with masks in the upper half |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, the OR of the status bits |

## Verification
The hardest case to reach is a clear of the completion flag that lands on the same edge as a completion. Software normally clears the flag only after it sees the flag set. The bench therefore starts a read and then counts edges itself. It issues the clearing write so that its strobe is sampled on exactly the fourth edge after the start, and then reads status to confirm that the set won. A related case is a start that arrives mid-read, after the address register has been rewritten. The bench reaches it with back-to-back writes on consecutive edges and checks which byte is returned.

// File: rtl/otpr_pkg.sv
package otpr_pkg;
  localparam logic [11:0] OFF_MODE  = 12'h100;
  localparam logic [11:0] OFF_ADDR  = 12'h104;
  localparam logic [11:0] OFF_START = 12'h108;
  localparam logic [11:0] OFF_DATA  = 12'h124;
  localparam logic [11:0] OFF_FLAGS = 12'h304;
  localparam int          FLAG_USER = 2;
  localparam int          MASK_SH   = 16;

  function automatic logic [7:0] fuse_pattern(int unsigned idx);
    return 8'((idx * 13 + 41) & 255);
  endfunction
endpackage

// File: rtl/otpr_array.sv
module otpr_array #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       dout
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = otpr_pkg::fuse_pattern(i);
  end

  always_ff @(posedge clk) dout <= mem[idx];
endmodule

// File: rtl/otpr_engine.sv
module otpr_engine #(
  parameter int IDX_W = 8,
  parameter int LAT   = 4,
  localparam int CW   = (LAT > 2) ? $clog2(LAT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [IDX_W-1:0] addr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [CW-1:0] cnt_q;

  // completion is the last busy cycle; the array output is stable by then
  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      idx_o  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(LAT - 1);
      idx_o  <= addr_i;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/otp_user_reader.sv
module otp_user_reader #(
  parameter int ARRAY_DEPTH = 256,
  parameter int ACCESS_LAT  = 4,
  parameter int BUS_AW      = 12,
  localparam int IDX_W      = $clog2(ARRAY_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import otpr_pkg::*;

  logic             mode_q;
  logic [15:0]      addr_q;
  logic [7:0]       data_q;
  logic             flag_q;
  logic [31:0]      flags_vec;
  logic [31:0]      rd_mux;
  logic             eng_busy, eng_done, start_req;
  logic [IDX_W-1:0] eng_idx;
  logic [7:0]       arr_dout;

  logic wr_mode, wr_addr, wr_start, wr_flags;
  assign wr_mode  = bus_wr && (bus_addr == BUS_AW'(OFF_MODE));
  assign wr_addr  = bus_wr && (bus_addr == BUS_AW'(OFF_ADDR));
  assign wr_start = bus_wr && (bus_addr == BUS_AW'(OFF_START));
  assign wr_flags = bus_wr && (bus_addr == BUS_AW'(OFF_FLAGS));

  assign start_req = wr_start && bus_wdata[0] && bus_wdata[MASK_SH] && mode_q;

  otpr_engine #(.IDX_W(IDX_W), .LAT(ACCESS_LAT)) u_engine (
    .clk(clk), .rst(rst), .start_i(start_req), .addr_i(addr_q[IDX_W-1:0]),
    .busy_o(eng_busy), .done_o(eng_done), .idx_o(eng_idx)
  );

  otpr_array #(.DEPTH(ARRAY_DEPTH)) u_array (
    .clk(clk), .idx(eng_idx), .dout(arr_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_mode && bus_wdata[MASK_SH]) mode_q <= bus_wdata[0];
      if (wr_addr)
        addr_q <= (addr_q & ~bus_wdata[31:16]) | (bus_wdata[15:0] & bus_wdata[31:16]);
      if (eng_done) data_q <= arr_dout;
      // a completion outranks a clear on the same edge
      if (eng_done)                            flag_q <= 1'b1;
      else if (wr_flags && bus_wdata[FLAG_USER]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    flags_vec = '0;
    flags_vec[FLAG_USER] = flag_q;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      BUS_AW'(OFF_MODE):  rd_mux[0]    = mode_q;
      BUS_AW'(OFF_ADDR):  rd_mux[15:0] = addr_q;
      BUS_AW'(OFF_START): rd_mux[0]    = eng_busy;
      BUS_AW'(OFF_DATA):  rd_mux[7:0]  = data_q;
      BUS_AW'(OFF_FLAGS): rd_mux       = flags_vec;
      default:            rd_mux       = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = |flags_vec;
endmodule

// File: rtl/otpr_checker.sv
module otpr_checker #(
  parameter int BUS_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic              mode_q,
  input logic              flag_q,
  input logic [7:0]        data_q,
  input logic              eng_busy,
  input logic              eng_done
);
  // R2: an unmasked control write leaves the mode bit alone
  p_mode_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == BUS_AW'(12'h100) && !bus_wdata[16]) |=> $stable(mode_q));

  // R4: a completion sets the user flag on the next state
  p_done_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> flag_q);

  // R4: the data register moves only on a completion
  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !eng_done |=> $stable(data_q));

  // R6: a read only begins while user mode is on
  p_start_needs_mode_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(mode_q));

  // R8: a clear without a coinciding completion drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == BUS_AW'(12'h304) && bus_wdata[2] && !eng_done) |=> !flag_q);

  // R9: the interrupt only falls after a clearing write
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(bus_wr && bus_addr == BUS_AW'(12'h304) && bus_wdata[2]));
endmodule

bind otp_user_reader otpr_checker #(.BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .mode_q(mode_q), .flag_q(flag_q),
  .data_q(data_q), .eng_busy(eng_busy), .eng_done(eng_done)
);

// File: tb/otp_user_reader_bench.sv
module otp_user_reader_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  otp_user_reader u_otp_user_reader (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] expect_byte(int unsigned a);
    return 32'(((a % 256) * 13 + 'h29) % 256);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(12'h100, v); chk("R1 mode", v, 0);
    rd(12'h104, v); chk("R1 addr", v, 0);
    rd(12'h124, v); chk("R1 data", v, 0);
    rd(12'h304, v); chk("R1 flags", v, 0);
  endtask

  task automatic t_mode_mask;
    logic [31:0] v;
    wr(12'h100, 32'h0000_0001); rd(12'h100, v); chk("R2 unmasked set", v, 0);
    wr(12'h100, 32'h0001_0001); rd(12'h100, v); chk("R2 masked set", v, 1);
    wr(12'h100, 32'h0000_0000); rd(12'h100, v); chk("R2 unmasked clear", v, 1);
  endtask

  task automatic t_addr_mask;
    logic [31:0] v;
    wr(12'h104, 32'hFFFF_1234); rd(12'h104, v); chk("R3 full", v, 32'h1234);
    wr(12'h104, 32'h00FF_AB56); rd(12'h104, v); chk("R3 low byte", v, 32'h1256);
    wr(12'h104, 32'h0000_FFFF); rd(12'h104, v); chk("R3 no mask", v, 32'h1256);
  endtask

  // start a read and check its completion edge through irq
  task automatic read_at(int unsigned a);
    logic [31:0] v;
    wr(12'h104, {16'hFFFF, 16'(a)});
    wr(12'h108, 32'h0001_0001);
    repeat (3) @(posedge clk); #1;
    chk("R4 not early", {31'b0, irq}, 0);
    @(posedge clk); #1;
    chk("R4 on time", {31'b0, irq}, 1);
    chk("R9 irq with flag", {31'b0, irq}, 1);
    rd(12'h124, v); chk("R5 byte", v, expect_byte(a));
    rd(12'h304, v); chk("R8 flag set", v, 32'h4);
    wr(12'h304, 32'h0000_0000); rd(12'h304, v); chk("R8 zero write", v, 32'h4);
    wr(12'h304, 32'h0000_0004); rd(12'h304, v); chk("R8 cleared", v, 0);
    chk("R9 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_reads;
    read_at(16'h1256);
    read_at(0);
    read_at(255);
    read_at(256);
    read_at(16'hABCD);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    wr(12'h104, 32'hFFFF_0010);
    wr(12'h108, 32'h0001_0001);
    wr(12'h104, 32'hFFFF_0020);
    wr(12'h108, 32'h0001_0001);
    rd(12'h108, v); chk("R4 busy readback", v, 1);
    repeat (2) @(posedge clk); #1;
    rd(12'h124, v); chk("R7 first address kept", v, expect_byte(16'h10));
    wr(12'h304, 32'h4);
    repeat (8) @(posedge clk); #1;
    rd(12'h304, v); chk("R7 no second read", v, 0);
    rd(12'h108, v); chk("R7 idle", v, 0);
  endtask

  task automatic t_clear_race;
    logic [31:0] v;
    wr(12'h104, 32'hFFFF_0033);
    wr(12'h108, 32'h0001_0001);
    repeat (3) @(posedge clk);
    wr(12'h304, 32'h4);
    rd(12'h304, v); chk("R8 set wins", v, 32'h4);
    wr(12'h304, 32'h4);
  endtask

  task automatic t_mode_off;
    logic [31:0] v;
    wr(12'h100, 32'h0001_0000);
    rd(12'h100, v); chk("R2 masked clear", v, 0);
    wr(12'h104, 32'hFFFF_0044);
    wr(12'h108, 32'h0001_0001);
    repeat (8) @(posedge clk); #1;
    chk("R6 no irq", {31'b0, irq}, 0);
    rd(12'h108, v); chk("R6 not busy", v, 0);
    rd(12'h124, v); chk("R6 data kept", v, expect_byte(16'h33));
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R10 0x000", v, 0);
    rd(12'h200, v); chk("R10 0x200", v, 0);
    rd(12'h120, v); chk("R10 0x120", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_mode_mask();
    t_addr_mask();
    t_reads();
    t_busy_ignore();
    t_clear_race();
    t_mode_off();
    t_unmapped();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule